// File: doc/BRIEF.md
# Pixel-Clock PLL Divider Search Engine

This block turns a requested pixel clock, given in kHz, into the three PLL divider settings whose output comes closest to that request: a reference divider, a feedback loop multiplier and an output divider. The synthesized frequency follows integer arithmetic. The 100000 kHz reference is divided by the reference divider and the quotient is truncated. That result is multiplied by the loop multiplier, then divided by the output divider and truncated again.

A request is first matched against a fixed table of pre-solved clocks. A match is answered at once. Otherwise the engine walks every legal divider combination in a fixed nested order and keeps the best one found. It stops early on an exact hit. At the end it reports whether the best error falls under a 1000 kHz tolerance. The two divisions for each candidate share one iterative restoring divider, which retires a parameterised number of quotient bits per cycle.

A client offers a target with `req_valid` while `req_ready` is high. It later receives a one-cycle `res_valid` pulse together with the triple, a found flag and the residual error. These stay in place until the next request is accepted.

Top module: `pll_param_search`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` and `res_found` are 0, and `res_dout`, `res_loopc`, `res_dref` and `res_err` are all 0.
- R2: A target held in the pre-solved table returns that entry's triple with `res_found`=1 and `res_err`=0, without searching. Three entries are 148500 kHz → output divider 11, loop 49, reference 3; 65000 kHz → 20, 39, 3; and 25175 kHz → 85, 107, 5. The 25175 entry is returned even though it would compute to 25176.
- R3: For a table hit or a zero target, `res_valid` is high after the second rising edge, counting the edge that accepts the request as the first.
- R4: A target of 0 returns `res_found`=0, `res_err`=1000 and an all-zero triple, without searching.
- R5: Each candidate frequency is (100000 / ref) * loop / out, truncated after each division. The ranges are out 6..63, ref 3..5 and loop 6..160. Only loop values with 12*ref ≤ loop ≤ 32*ref are evaluated.
- R6: The output divider is the outer loop, the reference divider the middle loop and the loop multiplier the inner loop, each ascending. The kept candidate changes only on a strictly smaller absolute error, so the earliest of equal-error candidates wins.
- R7: A candidate with zero error ends the search at once and is reported with `res_found`=1 and `res_err`=0.
- R8: The best error starts at 1000. After a full sweep, `res_found` is 1 only if the best error is below 1000. If nothing beat 1000, the result is `res_found`=0, `res_err`=1000 and an all-zero triple.
- R9: `req_ready` is 0 from acceptance until the result is delivered. `req_valid` during that time is ignored: it yields neither a second result nor a change to the first.
- R10: `res_valid` is a single-cycle pulse, and all result fields hold their values until the next accepted request completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Target offered |
| req_khz | input | FREQ_W | Target pixel clock in kHz |
| req_ready | output | 1 | Engine idle, request will be accepted |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | Best error below tolerance |
| res_dout | output | 7 | Chosen output divider |
| res_loopc | output | 9 | Chosen loop multiplier |
| res_dref | output | 7 | Chosen reference divider |
| res_err | output | FREQ_W | Absolute error of the chosen triple in kHz |

## Verification
The bench keeps the default divider ranges, tolerance and 24-bit frequency width. It sets the divider to retire 12 quotient bits per cycle, so every division costs two cycles. With that setting, a complete sweep of roughly fourteen thousand candidates fits comfortably in the run. Both exhaustive outcomes can then be observed: a target that no candidate approaches, and an inexact target whose best error must be matched against an independent walk of the same loops. The same setting keeps the cycle count of an exact first-candidate hit small enough to check against the early-exit requirement.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  localparam int DOUT_W = 7;
  localparam int LC_W   = 9;
  localparam int DREF_W = 7;

  typedef struct packed {
    logic [DOUT_W-1:0] dout;
    logic [LC_W-1:0]   loopc;
    logic [DREF_W-1:0] dref;
  } pll_triple_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_REF_GO,
    S_REF_WAIT,
    S_CAND_GO,
    S_CAND_WAIT
  } srch_state_t;

endpackage

// File: rtl/pllsrch_rom.sv
module pllsrch_rom
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W = 24
) (
  input  logic [FREQ_W-1:0] key_khz,
  output logic              hit,
  output pll_triple_t       val
);

  function automatic pll_triple_t mk(input int o, input int l, input int r);
    pll_triple_t t;
    t.dout  = DOUT_W'(o);
    t.loopc = LC_W'(l);
    t.dref  = DREF_W'(r);
    return t;
  endfunction

  // pre-solved clocks, ascending frequency: (out, loop, ref)
  always_comb begin
    hit = 1'b1;
    val = '0;
    case (32'(key_khz))
      32'd25175:  val = mk(85, 107, 5);
      32'd25200:  val = mk(50, 63, 5);
      32'd27000:  val = mk(50, 54, 4);
      32'd30240:  val = mk(62, 75, 4);
      32'd31500:  val = mk(40, 63, 5);
      32'd36000:  val = mk(50, 72, 4);
      32'd40000:  val = mk(30, 36, 3);
      32'd49500:  val = mk(40, 99, 5);
      32'd50000:  val = mk(44, 88, 4);
      32'd51200:  val = mk(25, 64, 5);
      32'd57284:  val = mk(24, 55, 4);
      32'd65000:  val = mk(20, 39, 3);
      32'd71000:  val = mk(20, 71, 5);
      32'd74250:  val = mk(22, 49, 3);
      32'd75000:  val = mk(29, 87, 4);
      32'd78750:  val = mk(16, 63, 5);
      32'd83500:  val = mk(17, 71, 5);
      32'd88750:  val = mk(16, 71, 5);
      32'd106500: val = mk(19, 81, 4);
      32'd108000: val = mk(15, 81, 5);
      32'd119000: val = mk(20, 119, 5);
      32'd135000: val = mk(10, 54, 4);
      32'd141750: val = mk(11, 78, 5);
      32'd146250: val = mk(16, 117, 5);
      32'd148500: val = mk(11, 49, 3);
      32'd174500: val = mk(17, 89, 3);
      32'd181250: val = mk(8, 58, 4);
      32'd297000: val = mk(8, 95, 4);
      32'd301992: val = mk(10, 151, 5);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pllsrch_divider.sv
module pllsrch_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 7,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int STEPS = NUM_W / STEP;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [DEN_W:0]   rem_q, rem_n;
  logic [NUM_W-1:0] quo_q, quo_n;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;

  // STEP restoring iterations per cycle
  always_comb begin
    logic [DEN_W:0]   r;
    logic [NUM_W-1:0] q;
    r = rem_q;
    q = quo_q;
    for (int i = 0; i < STEP; i++) begin
      r = {r[DEN_W-1:0], q[NUM_W-1]};
      q = {q[NUM_W-2:0], 1'b0};
      if (r >= {1'b0, den_q}) begin
        r    = r - {1'b0, den_q};
        q[0] = 1'b1;
      end
    end
    rem_n = r;
    quo_n = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(STEPS);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;

  p_div_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_den_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (den != '0));

endmodule

// File: rtl/pllsrch_ctrl.sv
module pllsrch_ctrl
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 24,
  parameter int REF_KHZ   = 100000,
  parameter int TOL_KHZ   = 1000,
  parameter int DOUT_MIN  = 6,
  parameter int DOUT_MAX  = 63,
  parameter int DREF_MIN  = 3,
  parameter int DREF_MAX  = 5,
  parameter int LC_MIN    = 6,
  parameter int LC_MAX    = 160,
  parameter int LC_LO_MUL = 12,
  parameter int LC_HI_MUL = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_khz,
  output logic              req_ready,
  output logic [FREQ_W-1:0] lookup_key,
  input  logic              rom_hit,
  input  pll_triple_t       rom_val,
  output logic              div_start,
  output logic [FREQ_W-1:0] div_num,
  output logic [DOUT_W-1:0] div_den,
  input  logic              div_busy,
  input  logic              div_done,
  input  logic [FREQ_W-1:0] div_quo,
  output logic              res_valid,
  output logic              res_found,
  output pll_triple_t       res_trip,
  output logic [FREQ_W-1:0] res_err
);

  localparam logic [DOUT_W-1:0] OUT_LO = DOUT_W'(DOUT_MIN);
  localparam logic [DOUT_W-1:0] OUT_HI = DOUT_W'(DOUT_MAX);
  localparam logic [DREF_W-1:0] REF_LO = DREF_W'(DREF_MIN);
  localparam logic [DREF_W-1:0] REF_HI = DREF_W'(DREF_MAX);
  localparam logic [LC_W-1:0]   LC_LO  = LC_W'(LC_MIN);
  localparam logic [LC_W-1:0]   LC_HI  = LC_W'(LC_MAX);
  localparam logic [FREQ_W-1:0] TOL    = FREQ_W'(TOL_KHZ);
  localparam logic [FREQ_W-1:0] REFV   = FREQ_W'(REF_KHZ);
  localparam int                MW     = LC_W + DREF_W;

  srch_state_t       state_q;
  logic [FREQ_W-1:0] tgt_q, q1_q, best_err_q, diff, cand;
  logic [DOUT_W-1:0] dout_q;
  logic [DREF_W-1:0] dref_q;
  logic [LC_W-1:0]   loopc_q, win_lo, win_hi;
  pll_triple_t       best_q, cur_trip;
  logic [MW-1:0]     lo_raw, hi_raw;
  logic [FREQ_W+LC_W-1:0] prod;
  logic              in_win;

  // legal loop window for the current reference divider
  always_comb begin
    lo_raw = MW'(LC_LO_MUL) * {{LC_W{1'b0}}, dref_q};
    hi_raw = MW'(LC_HI_MUL) * {{LC_W{1'b0}}, dref_q};
    win_lo = (lo_raw < MW'(LC_MIN)) ? LC_LO : lo_raw[LC_W-1:0];
    win_hi = (hi_raw > MW'(LC_MAX)) ? LC_HI : hi_raw[LC_W-1:0];
  end

  assign in_win   = (loopc_q <= win_hi);
  assign prod     = {{LC_W{1'b0}}, q1_q} * {{FREQ_W{1'b0}}, loopc_q};
  assign cand     = div_quo;
  assign diff     = (cand >= tgt_q) ? (cand - tgt_q) : (tgt_q - cand);
  assign cur_trip = '{dout: dout_q, loopc: loopc_q, dref: dref_q};

  assign req_ready  = (state_q == S_IDLE);
  assign lookup_key = tgt_q;
  assign div_start  = (state_q == S_REF_GO) || ((state_q == S_CAND_GO) && in_win);
  assign div_num    = (state_q == S_REF_GO) ? REFV : prod[FREQ_W-1:0];
  assign div_den    = (state_q == S_REF_GO) ? DOUT_W'(dref_q) : dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      tgt_q      <= '0;
      q1_q       <= '0;
      best_err_q <= '0;
      best_q     <= '0;
      dout_q     <= '0;
      dref_q     <= '0;
      loopc_q    <= '0;
      res_valid  <= 1'b0;
      res_found  <= 1'b0;
      res_trip   <= '0;
      res_err    <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            tgt_q   <= req_khz;
            state_q <= S_LOOKUP;
          end
        end
        S_LOOKUP: begin
          if (tgt_q == '0) begin
            res_valid <= 1'b1;
            res_found <= 1'b0;
            res_trip  <= '0;
            res_err   <= TOL;
            state_q   <= S_IDLE;
          end else if (rom_hit) begin
            res_valid <= 1'b1;
            res_found <= 1'b1;
            res_trip  <= rom_val;
            res_err   <= '0;
            state_q   <= S_IDLE;
          end else begin
            dout_q     <= OUT_LO;
            dref_q     <= REF_LO;
            best_err_q <= TOL;
            best_q     <= '0;
            state_q    <= S_REF_GO;
          end
        end
        S_REF_GO: state_q <= S_REF_WAIT;
        S_REF_WAIT: begin
          if (div_done) begin
            q1_q    <= div_quo;
            loopc_q <= win_lo;
            state_q <= S_CAND_GO;
          end
        end
        S_CAND_GO: begin
          if (in_win) begin
            state_q <= S_CAND_WAIT;
          end else if (dref_q < REF_HI) begin
            dref_q  <= dref_q + 1'b1;
            state_q <= S_REF_GO;
          end else if (dout_q < OUT_HI) begin
            dout_q  <= dout_q + 1'b1;
            dref_q  <= REF_LO;
            state_q <= S_REF_GO;
          end else begin
            res_valid <= 1'b1;
            res_found <= (best_err_q < TOL);
            res_trip  <= best_q;
            res_err   <= best_err_q;
            state_q   <= S_IDLE;
          end
        end
        S_CAND_WAIT: begin
          if (div_done) begin
            if (diff < best_err_q) begin
              best_err_q <= diff;
              best_q     <= cur_trip;
            end
            if (diff == '0) begin
              res_valid <= 1'b1;
              res_found <= 1'b1;
              res_trip  <= cur_trip;
              res_err   <= '0;
              state_q   <= S_IDLE;
            end else begin
              loopc_q <= loopc_q + 1'b1;
              state_q <= S_CAND_GO;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_start_free_r5: assert property (@(posedge clk) disable iff (rst)
    div_start |-> !div_busy);
  p_loopc_window_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CAND_WAIT) |-> (loopc_q >= win_lo) && (loopc_q <= win_hi));
  p_prod_fits_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CAND_GO && in_win) |-> (prod[FREQ_W+LC_W-1:FREQ_W] == '0));
  p_best_monotone_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && state_q != S_LOOKUP && $past(state_q) != S_LOOKUP)
      |-> (best_err_q <= $past(best_err_q)));
  p_found_err_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_found) |-> (res_err < TOL));
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> (tgt_q == $past(tgt_q)));
  p_res_idle_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> req_ready);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_err) && $stable(res_trip) && $stable(res_found)));

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pllsrch_pkg::*;
#(
  parameter int FREQ_W    = 24,
  parameter int REF_KHZ   = 100000,
  parameter int TOL_KHZ   = 1000,
  parameter int DOUT_MIN  = 6,
  parameter int DOUT_MAX  = 63,
  parameter int DREF_MIN  = 3,
  parameter int DREF_MAX  = 5,
  parameter int LC_MIN    = 6,
  parameter int LC_MAX    = 160,
  parameter int LC_LO_MUL = 12,
  parameter int LC_HI_MUL = 32,
  parameter int DIV_STEP  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_khz,
  output logic              req_ready,
  output logic              res_valid,
  output logic              res_found,
  output logic [6:0]        res_dout,
  output logic [8:0]        res_loopc,
  output logic [6:0]        res_dref,
  output logic [FREQ_W-1:0] res_err
);

  logic [FREQ_W-1:0] key, div_num, div_quo;
  logic [DOUT_W-1:0] div_den;
  logic              rom_hit, div_start, div_busy, div_done;
  pll_triple_t       rom_val, res_trip;

  pllsrch_rom #(.FREQ_W(FREQ_W)) u_rom (
    .key_khz (key),
    .hit     (rom_hit),
    .val     (rom_val)
  );

  pllsrch_divider #(.NUM_W(FREQ_W), .DEN_W(DOUT_W), .STEP(DIV_STEP)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  pllsrch_ctrl #(
    .FREQ_W(FREQ_W), .REF_KHZ(REF_KHZ), .TOL_KHZ(TOL_KHZ),
    .DOUT_MIN(DOUT_MIN), .DOUT_MAX(DOUT_MAX),
    .DREF_MIN(DREF_MIN), .DREF_MAX(DREF_MAX),
    .LC_MIN(LC_MIN), .LC_MAX(LC_MAX),
    .LC_LO_MUL(LC_LO_MUL), .LC_HI_MUL(LC_HI_MUL)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_khz    (req_khz),
    .req_ready  (req_ready),
    .lookup_key (key),
    .rom_hit    (rom_hit),
    .rom_val    (rom_val),
    .div_start  (div_start),
    .div_num    (div_num),
    .div_den    (div_den),
    .div_busy   (div_busy),
    .div_done   (div_done),
    .div_quo    (div_quo),
    .res_valid  (res_valid),
    .res_found  (res_found),
    .res_trip   (res_trip),
    .res_err    (res_err)
  );

  assign res_dout  = res_trip.dout;
  assign res_loopc = res_trip.loopc;
  assign res_dref  = res_trip.dref;

endmodule

// File: tb/pll_param_search_tb_top.sv
module pll_param_search_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_khz = '0;
  logic        req_ready, res_valid, res_found;
  logic [6:0]  res_dout, res_dref;
  logic [8:0]  res_loopc;
  logic [23:0] res_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  pll_param_search #(.DIV_STEP(12)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_khz(req_khz),
    .req_ready(req_ready), .res_valid(res_valid), .res_found(res_found),
    .res_dout(res_dout), .res_loopc(res_loopc), .res_dref(res_dref),
    .res_err(res_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // independent walk of the search
  function automatic void model(input int unsigned t, output int unsigned o_do,
      output int unsigned o_lc, output int unsigned o_dr, output int unsigned o_err,
      output bit o_found);
    int unsigned best = 1000;
    o_do = 0; o_lc = 0; o_dr = 0; o_found = 0;
    for (int unsigned d_o = 6; d_o <= 63; d_o++)
      for (int unsigned d_r = 3; d_r <= 5; d_r++)
        for (int unsigned l = 6; l <= 160; l++) begin
          int unsigned c, df;
          if (l < 12 * d_r || l > 32 * d_r) continue;
          c  = 100000 / d_r * l / d_o;
          df = (c >= t) ? c - t : t - c;
          if (df < best) begin
            best = df; o_do = d_o; o_lc = l; o_dr = d_r;
            if (df == 0) begin
              o_err = 0; o_found = 1;
              return;
            end
          end
        end
    o_err = best;
    o_found = (best < 1000);
  endfunction

  task automatic do_req(input int unsigned t, output int n);
    @(negedge clk);
    req_khz = t[23:0];
    req_valid = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req_valid = 1'b0;
      if (res_valid || n > 80000) break;
    end
  endtask

  task automatic chk_result(input string req, input bit f, input int unsigned o,
      input int unsigned l, input int unsigned r, input int unsigned e);
    chk(res_found == f, req, "found", res_found, f);
    chk(res_dout == o, req, "out divider", res_dout, o);
    chk(res_loopc == l, req, "loop", res_loopc, l);
    chk(res_dref == r, req, "ref divider", res_dref, r);
    chk(res_err == e, req, "error", res_err, e);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1", "valid", res_valid, 0);
    chk_result("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_table();
    int n;
    do_req(148500, n);
    chk(n == 2, "R3", "table latency", n, 2);
    chk_result("R2", 1, 11, 49, 3, 0);
    do_req(65000, n);
    chk_result("R2", 1, 20, 39, 3, 0);
    do_req(25175, n);
    chk(n == 2, "R3", "table latency", n, 2);
    chk_result("R2", 1, 85, 107, 5, 0);
  endtask

  task automatic t_zero();
    int n;
    do_req(0, n);
    chk(n == 2, "R3", "zero latency", n, 2);
    chk_result("R4", 0, 0, 0, 0, 1000);
  endtask

  task automatic t_search(input int unsigned t, input string req);
    int n;
    int unsigned o, l, r, e;
    bit f;
    model(t, o, l, r, e, f);
    do_req(t, n);
    chk(res_valid == 1'b1, req, "result delivered", res_valid, 1);
    chk_result(req, f, o, l, r, e);
  endtask

  task automatic t_early();
    int n;
    int unsigned o, l, r, e;
    bit f;
    model(199998, o, l, r, e, f);
    do_req(199998, n);
    chk(n <= 12, "R7", "early exit cycles", n, 12);
    chk_result("R7", f, o, l, r, e);
  endtask

  task automatic t_busy();
    int n = 0;
    int unsigned o, l, r, e;
    bit f;
    bit extra = 1'b0;
    model(100000, o, l, r, e, f);
    @(negedge clk);
    req_khz = 24'd100000;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
    req_khz = 24'd65000;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid && n < 80000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk_result("R9", f, o, l, r, e);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10", "single pulse", res_valid, 0);
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (res_valid) extra = 1'b1;
    end
    chk(extra == 1'b0, "R9", "ignored request produced result", extra, 0);
    chk_result("R10", f, o, l, r, e);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_table();
    t_zero();
    t_early();
    t_busy();                     // R5 R6 via model walk as well
    t_search(123457, "R6");
    t_search(10000000, "R8");
    finish_run();
  end

endmodule